// File: doc/BRIEF.md
# Clock-Generator Configuration Slave (Two-Wire Block Transfer)

This block is a two-wire serial slave that holds the configuration bank of a clock generator: seven 8-bit registers, presented in parallel on one output bus. A host writes the bank with a block-write sequence. After the write address, it sends two header bytes (a command code and a byte count). The slave acknowledges both and throws their values away. The data bytes that follow fill the registers strictly from register 0 upward. A host reads the bank with a block-read sequence. After the read address, the slave returns a byte count and then the whole bank in order. There is no register pointer, so every access starts at register 0.

SCL and SDA are oversampled by the system clock through two-flop synchronisers. Start and stop conditions are seen as SDA edges while SCL is high. The slave never stretches the clock. It pulls SDA only to acknowledge or to send read data, and the pad driver outside the block turns `sda_oe` into an open-drain pull-down.

Top module: `cfg_block_slave`

## Requirements
- R1: The slave answers only the 7-bit address 0x69, which gives the address byte 0xD2 for a write and 0xD3 for a read. It acknowledges that byte with SDA low. For any other address byte it leaves SDA released (the host reads 1), ignores the rest of the transfer and changes no register.
- R2: In a write, the two bytes after the address are acknowledged, and their values have no effect on which registers are written or how many.
- R3: Write data bytes are stored one per byte, in ascending order from register 0 to register 6. Register n occupies bits [8n+7:8n] of `regs_o`, and each byte is stored as received, MSB first.
- R4: A stop after any complete byte ends the write. Registers already written keep their new values, and the remaining registers keep their previous values.
- R5: Data bytes after the seventh in one write are acknowledged and discarded.
- R6: After reset, `regs_o` equals the default bank 0x55_0A_3C_FF_FF_FF_00 (register 6 down to register 0, so register 0 resets to 0x00), and `sda_oe` is low.
- R7: In a read, the slave sends the byte count 0x07 and then registers 0 through 6, each MSB first. It goes on to the next byte only after the host acknowledges.
- R8: The slave pulls SDA low for the whole ninth SCL period after each byte it accepts. Outside those periods it releases SDA, except while it drives read data bits, and SDA is released whenever the bus is idle.
- R9: A host NACK after a read byte ends the transfer. The slave then keeps SDA released through any further SCL pulses until the next start condition.
- R10: A repeated start drops the current transfer and begins a new address phase. It leaves every register as it was at that moment, and the next write starts again at register 0.
- R11: The slave works with SCL high and low phases of 8 system clocks or longer. With a system clock of 2 MHz or more, this covers standard-mode timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low reset, loads the default bank |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | High means pull SDA low |
| regs_o | output | 56 | Register bank, register n in bits [8n+7:8n] |

## Verification
The bench tries full block writes whose count byte disagrees with the real number of data bytes. This shows whether the header is truly ignored or used as a length. Short writes that stop after three bytes and long writes with nine data bytes separate the per-byte commit from the upper limit of the bank. A foreign address followed by more data shows that a mismatched slave stays silent. Full reads, a read cut short by a NACK and followed by extra SCL pulses, a write interrupted by a repeated start into a read, and one read with 8-clock SCL phases separate read sequencing, bus release and restart handling from the plain write path.

// File: rtl/cfg_block_slave.sv
module cfg_block_slave #(
  parameter logic [6:0]        DEV_ADDR = 7'h69,
  parameter int                NREG     = 7,
  parameter logic [NREG*8-1:0] RST_VAL  = 56'h55_0A_3C_FF_FF_FF_00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] regs_o
);

  localparam int            IW      = $clog2(NREG + 3);
  localparam logic [IW-1:0] IDX_MAX = IW'(NREG + 2);

  localparam logic [2:0] S_IDLE  = 3'd0;
  localparam logic [2:0] S_RX    = 3'd1;
  localparam logic [2:0] S_RXACK = 3'd2;
  localparam logic [2:0] S_TX    = 3'd3;
  localparam logic [2:0] S_TXACK = 3'd4;

  logic [2:0]        scl_s, sda_s;
  logic [2:0]        st;
  logic [3:0]        bitcnt;
  logic [IW-1:0]     idx;
  logic [7:0]        sr;
  logic [7:0]        tx_byte;
  logic              rw, addr_ph;
  logic [NREG*8-1:0] bank;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= 3'b111;
      sda_s <= 3'b111;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
    end

  wire scl_rise = scl_s[1] & ~scl_s[2];
  wire scl_fall = ~scl_s[1] & scl_s[2];
  wire scl_high = scl_s[1] & scl_s[2];
  wire start_c  = scl_high & ~sda_s[1] & sda_s[2];
  wire stop_c   = scl_high & sda_s[1] & ~sda_s[2];
  wire idx_inc  = (idx != IDX_MAX);

  always_comb begin
    tx_byte = 8'hFF;
    if (idx == '0) tx_byte = 8'(NREG);
    for (int i = 0; i < NREG; i++)
      if (idx == IW'(i + 1)) tx_byte = bank[8*i +: 8];
  end

  assign regs_o = bank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      bitcnt  <= '0;
      idx     <= '0;
      sr      <= '0;
      rw      <= 1'b0;
      addr_ph <= 1'b0;
      sda_oe  <= 1'b0;
      bank    <= RST_VAL;
    end else if (start_c) begin
      st      <= S_RX;
      bitcnt  <= '0;
      idx     <= '0;
      rw      <= 1'b0;
      addr_ph <= 1'b1;
      sda_oe  <= 1'b0;
    end else if (stop_c) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        S_RX: begin
          if (scl_rise && bitcnt != 4'd8) begin
            sr     <= {sr[6:0], sda_s[1]};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            bitcnt <= '0;
            if (addr_ph) begin
              if (sr[7:1] == DEV_ADDR) begin
                addr_ph <= 1'b0;
                rw      <= sr[0];
                sda_oe  <= 1'b1;
                st      <= S_RXACK;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              for (int i = 0; i < NREG; i++)
                if (idx == IW'(i + 2)) bank[8*i +: 8] <= sr;
              if (idx_inc) idx <= idx + 1'b1;
              sda_oe <= 1'b1;
              st     <= S_RXACK;
            end
          end
        end
        S_RXACK: begin
          if (scl_fall) begin
            if (rw) begin
              sr     <= tx_byte;
              sda_oe <= ~tx_byte[7];
              st     <= S_TX;
            end else begin
              sda_oe <= 1'b0;
              st     <= S_RX;
            end
          end
        end
        S_TX: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              bitcnt <= '0;
              sda_oe <= 1'b0;
              if (idx_inc) idx <= idx + 1'b1;
              st <= S_TXACK;
            end else begin
              sr     <= {sr[6:0], 1'b0};
              sda_oe <= ~sr[6];
            end
          end
        end
        S_TXACK: begin
          if (scl_rise) begin
            if (sda_s[1]) st <= S_IDLE;
          end else if (scl_fall) begin
            sr     <= tx_byte;
            sda_oe <= ~tx_byte[7];
            st     <= S_TX;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cfg_block_slave_chk.sv
module cfg_block_slave_chk #(
  parameter int                NREG    = 7,
  parameter logic [NREG*8-1:0] RST_VAL = 56'h55_0A_3C_FF_FF_FF_00
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic [NREG*8-1:0] regs_o,
  input logic [2:0]        st
);

  logic [NREG*8-1:0] prev_regs;
  logic [NREG-1:0]   chg;

  always_ff @(posedge clk) prev_regs <= regs_o;

  always_comb
    for (int i = 0; i < NREG; i++)
      chg[i] = (regs_o[8*i +: 8] != prev_regs[8*i +: 8]);

  AST_RESET_DEFAULTS: assert property (@(posedge clk) $rose(rst_n) |-> (regs_o == RST_VAL)); // R6
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) (st == 3'd0) |-> !sda_oe); // R9
  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) !$stable(sda_oe) |-> !scl_i); // R8
  AST_REG_WRITE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) !$stable(regs_o) |-> !scl_i); // R3
  AST_ONE_BYTE_PER_STEP: assert property (@(posedge clk) disable iff (!rst_n) $past(rst_n) |-> ($countones(chg) <= 1)); // R3

endmodule

bind cfg_block_slave cfg_block_slave_chk #(.NREG(NREG), .RST_VAL(RST_VAL)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .regs_o(regs_o), .st(st)
);

// File: tb/sim_cfg_block_slave.sv
module sim_cfg_block_slave;
  localparam logic [55:0] DEF = 56'h55_0A_3C_FF_FF_FF_00;

  typedef struct { string req; logic [63:0] val; } item_t;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, m_low = 1'b0;
  wire        sda_oe;
  wire [55:0] regs;
  wire        sda_bus = ~(m_low | sda_oe);

  always #5 clk = ~clk;

  cfg_block_slave u0 (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
                      .sda_oe(sda_oe), .regs_o(regs));

  item_t       exp_q[$];
  item_t       obs_q[$];
  event        obs_ev;
  int          hp = 5;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;
  logic [55:0] model = DEF;
  logic [7:0]  dbuf[16];

  task automatic push_exp(input string r, input logic [63:0] v);
    exp_q.push_back('{r, v});
  endtask

  task automatic push_obs(input logic [63:0] v);
    obs_q.push_back('{"", v});
    -> obs_ev;
  endtask

  task automatic drain();
    while (obs_q.size() > 0) begin
      item_t o = obs_q.pop_front();
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected item: actual %h expected none", o.val);
      end else begin
        item_t e = exp_q.pop_front();
        if (o.val !== e.val) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", e.req, o.val, e.val);
        end
      end
    end
  endtask

  initial forever begin
    @(obs_ev);
    drain();
  end

  task automatic half();
    repeat (hp) @(negedge clk);
  endtask

  task automatic bus_bit(input logic b, output logic rb);
    half(); m_low = ~b;
    half(); scl_m = 1'b1;
    half(); rb = sda_bus;
    half(); scl_m = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack_n);
    logic d;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], d);
    bus_bit(1'b1, ack_n);
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] b);
    logic d;
    for (int i = 7; i >= 0; i--) bus_bit(1'b1, b[i]);
    bus_bit(~mack, d);
  endtask

  task automatic bus_start(input logic rep);
    if (rep) begin
      half(); m_low = 1'b0;
      half(); scl_m = 1'b1;
    end
    half(); m_low = 1'b1;
    half(); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    half(); m_low = 1'b1;
    half(); scl_m = 1'b1;
    half(); m_low = 1'b0;
    half();
  endtask

  task automatic check_regs(input string r);
    repeat (4) @(negedge clk);
    push_exp(r, {8'h00, model}); push_obs({8'h00, regs});
    push_exp("R8", 64'd0);       push_obs({63'd0, sda_oe});
  endtask

  task automatic write_txn(input logic [7:0] cmd, input logic [7:0] cnt, input int n,
                           input logic rep);
    logic a;
    push_exp("R1", 0); push_exp("R2", 0); push_exp("R2", 0);
    for (int i = 0; i < n; i++) push_exp(i < 7 ? "R3" : "R5", 0);
    bus_start(rep);
    wr_byte(8'hD2, a); push_obs({63'd0, a});
    wr_byte(cmd, a);   push_obs({63'd0, a});
    wr_byte(cnt, a);   push_obs({63'd0, a});
    for (int i = 0; i < n; i++) begin
      wr_byte(dbuf[i], a); push_obs({63'd0, a});
      if (i < 7) model[8*i +: 8] = dbuf[i];
    end
  endtask

  task automatic read_txn(input int k, input logic rep, input string r);
    logic       a;
    logic [7:0] b;
    push_exp("R1", 0);
    for (int j = 0; j < k; j++)
      push_exp(r, (j == 0) ? 64'd7 : {56'd0, model[8*(j-1) +: 8]});
    bus_start(rep);
    wr_byte(8'hD3, a); push_obs({63'd0, a});
    for (int j = 0; j < k; j++) begin
      rd_byte(j != k - 1, b); push_obs({56'd0, b});
    end
  endtask

  initial begin
    logic       a;
    logic [7:0] b;
    repeat (5) @(negedge clk);
    // R6: reset state
    push_exp("R6", {8'h00, DEF}); push_obs({8'h00, regs});
    push_exp("R6", 0);            push_obs({63'd0, sda_oe});
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    push_exp("R6", {8'h00, DEF}); push_obs({8'h00, regs});

    // R2 R3: count byte says 3, seven bytes land anyway
    for (int i = 0; i < 7; i++) dbuf[i] = 8'h11 * (i + 1) ^ 8'hA0;
    write_txn(8'h5A, 8'h03, 7, 1'b0); bus_stop(); check_regs("R3");

    // R7: full read
    read_txn(8, 1'b0, "R7"); bus_stop();

    // R4: stop after three data bytes
    for (int i = 0; i < 3; i++) dbuf[i] = 8'h3C + 8'(i);
    write_txn(8'hFF, 8'h07, 3, 1'b0); bus_stop(); check_regs("R4");

    // R5: nine data bytes, extras acked and dropped
    for (int i = 0; i < 9; i++) dbuf[i] = 8'hC1 + 8'(i * 3);
    write_txn(8'h00, 8'h00, 9, 1'b0); bus_stop(); check_regs("R5");

    // R1: foreign address is not acked and changes nothing
    push_exp("R1", 1); push_exp("R1", 1);
    bus_start(1'b0);
    wr_byte(8'hA4, a); push_obs({63'd0, a});
    wr_byte(8'h00, a); push_obs({63'd0, a});
    bus_stop(); check_regs("R1");

    // R9: NACK after register 0, then the line stays released
    read_txn(2, 1'b0, "R9");
    push_exp("R9", 64'hFF);
    rd_byte(1'b0, b); push_obs({56'd0, b});
    bus_stop();

    // R10: write one byte, repeated start into a read, then restart write from reg 0
    dbuf[0] = 8'h5E;
    write_txn(8'h12, 8'h34, 1, 1'b0);
    read_txn(8, 1'b1, "R10");
    dbuf[0] = 8'h81; dbuf[1] = 8'h82;
    write_txn(8'h00, 8'h02, 2, 1'b1);
    bus_stop(); check_regs("R10");

    // R11: shortest supported SCL phases (8 system clocks)
    hp = 4;
    read_txn(8, 1'b0, "R11"); bus_stop();
    hp = 5;

    repeat (20) @(negedge clk);
    drain();
    if (exp_q.size() != 0) begin
      n_run++; n_fail++;
      $display("FAIL missing items: actual 0 expected %0d", exp_q.size());
    end
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule